// File: doc/BRIEF.md
# Dual-Mode FIFO With Programmable Flags

A single-clock FIFO that runs in one of two timing modes. The mode is fixed while reset is held. In standard mode a word leaves the FIFO only when the consumer asks for it. In fall-through mode an extra output register fetches the oldest word by itself, and that register counts as one more storage slot. The meaning and polarity of the two primary status pins change with the mode.

Each mode also drives an almost-empty flag and an almost-full flag. These compare the occupancy against an empty offset n and a full offset m. Two select pins, sampled during reset, choose the default value of both offsets. A separate loader can replace the offsets later through a parallel load strobe.

Top module: `fifo_dm`

## Requirements
- R1: `mode_sel` is sampled only while `rst_n` is low: 0 selects standard mode and 1 selects fall-through mode. Changing `mode_sel` after reset has no effect.
- R2: In reset the FIFO is empty, `ae_flag` is 0 and `af_flag` is 1. `rd_flag` is 0 in standard mode and 1 in fall-through mode. `wr_flag` is 1 in standard mode and 0 in fall-through mode.
- R3: In standard mode, `rd_en` with a non-empty FIFO places the oldest word on `rd_data` after that clock edge. Words leave in write order.
- R4: In standard mode, `rd_flag` is 1 exactly when the occupancy two edges earlier was non-zero. `wr_flag` is 0 exactly when that occupancy equalled DEPTH.
- R5: In fall-through mode the oldest word moves to `rd_data` without `rd_en`. `rd_flag` goes low three edges after the write edge of the first word, and then `rd_data` holds the oldest unread word. `rd_en` consumes that word.
- R6: Fall-through capacity is DEPTH+1 words. `wr_flag` is 1 exactly when the occupancy two edges earlier was DEPTH+1.
- R7: `ae_flag` is 1 when the occupancy at the previous edge exceeded n (standard mode) or n+1 (fall-through mode). Otherwise it is 0.
- R8: `af_flag` is 0 when the occupancy at the previous edge was at least DEPTH−m (standard mode) or DEPTH+1−m (fall-through mode). Otherwise it is 1.
- R9: `rd_en` is ignored while no word is held. Nothing is consumed and `rd_data` does not change.
- R10: Writes are ignored while the storage is full. A simultaneous read and write on a full standard-mode FIFO performs only the read.
- R11: During reset, `ofs_sel` sets both n and m: 2'b00 gives 7, 2'b10 gives 63, 2'b01 gives 127 and 2'b11 gives 255.
- R12: `ld_en` high at an edge loads n from `ld_empty_ofs` and m from `ld_full_ofs`. The flags use the new values from the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all state |
| rst_n | input | 1 | Synchronous reset, active low |
| mode_sel | input | 1 | Timing mode, sampled during reset |
| ofs_sel | input | 2 | Default offset code, sampled during reset |
| wr_en | input | 1 | Write request |
| wr_data | input | DW | Write word |
| rd_en | input | 1 | Read request |
| rd_data | output | DW | Read word |
| rd_flag | output | 1 | Standard mode: high when data is held. Fall-through mode: low when output is valid |
| wr_flag | output | 1 | Standard mode: low when full. Fall-through mode: high when full |
| ae_flag | output | 1 | Low while the FIFO is almost empty |
| af_flag | output | 1 | Low while the FIFO is almost full |
| ld_en | input | 1 | Offset load strobe |
| ld_empty_ofs | input | OFW | New empty offset n |
| ld_full_ofs | input | OFW | New full offset m |

## Verification
The bench drives the FIFO past both capacities, DEPTH in standard mode and DEPTH+1 in fall-through mode. A design that let an extra write in would corrupt the read order or pull `wr_flag` one edge early or late. It asserts `rd_en` on an empty FIFO and writes into a full one while also reading. A design that advanced a pointer on these would return words twice or skip them. It tracks the two-stage and three-stage flag lags and the n versus n+1 thresholds of each mode, where an off-by-one stage or threshold shows as a flag edge in the wrong cycle. Runs with all four reset offset codes and one mid-run load show whether a flag uses the wrong offset or applies it at the wrong time.

// File: rtl/fifo_dm_pkg.sv
package fifo_dm_pkg;

  // Offset value chosen by the select pins while reset is held
  function automatic int unsigned reset_offset(input logic [1:0] code);
    case (code)
      2'b11:   return 255;
      2'b01:   return 127;
      2'b10:   return 63;
      default: return 7;
    endcase
  endfunction

  // True while occupancy sits above the low mark (one word later in fall-through)
  function automatic logic over_low_mark(input int occ, input int ofs, input logic fall);
    return occ > ofs + int'(fall);
  endfunction

  // True once occupancy reaches the high mark; fall-through capacity is one more
  function automatic logic at_high_mark(input int occ, input int ofs, input int depth,
                                        input logic fall);
    return occ + ofs >= depth + int'(fall);
  endfunction

endpackage

// File: rtl/fifo_dm_store.sv
module fifo_dm_store #(
  parameter int DW    = 8,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int OCW  = $clog2(DEPTH + 2)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           fall,
  input  logic           wr_req,
  input  logic [DW-1:0]  wr_word,
  input  logic           rd_req,
  output logic [DW-1:0]  rd_word,
  output logic           out_valid,
  output logic [OCW-1:0] occ
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] cnt;
  logic          mem_full, mem_has, wr_take, rd_take, pop;

  assign mem_full = (cnt == CW'(DEPTH));
  assign mem_has  = (cnt != '0);
  assign wr_take  = wr_req & ~mem_full;
  assign rd_take  = fall ? (rd_req & out_valid) : (rd_req & mem_has);
  assign pop      = fall ? (mem_has & (~out_valid | rd_take)) : rd_take;
  assign occ      = OCW'(cnt) + OCW'(out_valid);

  always_ff @(posedge clk) begin
    if (wr_take) mem[wptr] <= wr_word;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr      <= '0;
      rptr      <= '0;
      cnt       <= '0;
      out_valid <= 1'b0;
      rd_word   <= '0;
    end else begin
      if (wr_take) wptr <= wptr + 1'b1;
      if (pop) begin
        rptr    <= rptr + 1'b1;
        rd_word <= mem[rptr];
      end
      cnt <= cnt + CW'(wr_take) - CW'(pop);
      if (!fall)        out_valid <= 1'b0;
      else if (pop)     out_valid <= 1'b1;
      else if (rd_take) out_valid <= 1'b0;
    end
  end

  a_r9_empty_read_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == '0) |=> $stable(rd_word));
  a_r10_read_only_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_full && pop) |=> (cnt == CW'(DEPTH - 1)));
  a_r6_capacity: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= OCW'(DEPTH + 1));
  a_r5_fetch_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(mem_has));
endmodule

// File: rtl/fifo_dm_pipe.sv
module fifo_dm_pipe #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] s;

  for (genvar gi = 0; gi < STAGES; gi++) begin : g_stage
    if (gi == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (!rst_n) s[0] <= 1'b0;
        else        s[0] <= din;
      end
    end else begin : g_tail
      always_ff @(posedge clk) begin
        if (!rst_n) s[gi] <= 1'b0;
        else        s[gi] <= s[gi-1];
      end
      a_r4_stage_shift: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (s[gi] == $past(s[gi-1])));
    end
  end

  assign dout = s[STAGES-1];
endmodule

// File: rtl/fifo_dm_marks.sv
module fifo_dm_marks
  import fifo_dm_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int OFW   = 9,
  parameter int OCW   = 5
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           fall,
  input  logic [1:0]     ofs_sel,
  input  logic           ld_en,
  input  logic [OFW-1:0] ld_n,
  input  logic [OFW-1:0] ld_m,
  input  logic [OCW-1:0] occ,
  output logic           ae_flag,
  output logic           af_flag
);
  logic [OFW-1:0] n_q, m_q;
  logic           above_low, at_high;

  assign above_low = over_low_mark(int'(occ), int'(n_q), fall);
  assign at_high   = at_high_mark(int'(occ), int'(m_q), DEPTH, fall);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      n_q     <= OFW'(reset_offset(ofs_sel));
      m_q     <= OFW'(reset_offset(ofs_sel));
      ae_flag <= 1'b0;
      af_flag <= 1'b1;
    end else begin
      if (ld_en) begin
        n_q <= ld_n;
        m_q <= ld_m;
      end
      ae_flag <= above_low;
      af_flag <= ~at_high;
    end
  end

  a_r12_offset_load: assert property (@(posedge clk) disable iff (!rst_n)
    ld_en |=> (n_q == $past(ld_n) && m_q == $past(ld_m)));
endmodule

// File: rtl/fifo_dm.sv
module fifo_dm #(
  parameter int DW    = 8,
  parameter int DEPTH = 16,
  parameter int OFW   = 9,
  localparam int OCW  = $clog2(DEPTH + 2)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           mode_sel,
  input  logic [1:0]     ofs_sel,
  input  logic           wr_en,
  input  logic [DW-1:0]  wr_data,
  input  logic           rd_en,
  output logic [DW-1:0]  rd_data,
  output logic           rd_flag,
  output logic           wr_flag,
  output logic           ae_flag,
  output logic           af_flag,
  input  logic           ld_en,
  input  logic [OFW-1:0] ld_empty_ofs,
  input  logic [OFW-1:0] ld_full_ofs
);
  logic           fall_q;
  logic [OCW-1:0] occ;
  logic           out_valid, has_raw, full_raw, has_late, valid_late, full_late;

  always_ff @(posedge clk) begin
    if (!rst_n) fall_q <= mode_sel;
  end

  fifo_dm_store #(.DW(DW), .DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n), .fall(fall_q),
    .wr_req(wr_en), .wr_word(wr_data), .rd_req(rd_en), .rd_word(rd_data),
    .out_valid(out_valid), .occ(occ)
  );

  assign has_raw  = (occ != '0);
  assign full_raw = (occ == (fall_q ? OCW'(DEPTH + 1) : OCW'(DEPTH)));

  fifo_dm_pipe #(.STAGES(2)) u_has_pipe (
    .clk(clk), .rst_n(rst_n), .din(has_raw), .dout(has_late));
  fifo_dm_pipe #(.STAGES(2)) u_valid_pipe (
    .clk(clk), .rst_n(rst_n), .din(out_valid), .dout(valid_late));
  fifo_dm_pipe #(.STAGES(2)) u_full_pipe (
    .clk(clk), .rst_n(rst_n), .din(full_raw), .dout(full_late));

  assign rd_flag = fall_q ? ~valid_late : has_late;
  assign wr_flag = fall_q ? full_late : ~full_late;

  fifo_dm_marks #(.DEPTH(DEPTH), .OFW(OFW), .OCW(OCW)) u_marks (
    .clk(clk), .rst_n(rst_n), .fall(fall_q), .ofs_sel(ofs_sel),
    .ld_en(ld_en), .ld_n(ld_empty_ofs), .ld_m(ld_full_ofs), .occ(occ),
    .ae_flag(ae_flag), .af_flag(af_flag)
  );

  a_r1_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> $stable(fall_q));
  a_r10_std_capacity: assert property (@(posedge clk) disable iff (!rst_n)
    !fall_q |-> (occ <= OCW'(DEPTH)));
endmodule

// File: tb/fifo_dm_tb_top.sv
module fifo_dm_tb_top;
  localparam int DW = 8;
  localparam int D  = 128;
  localparam int OFW = 9;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n = 1'b0, mode_sel = 1'b0, wr_en = 1'b0, rd_en = 1'b0, ld_en = 1'b0;
  logic [1:0] ofs_sel = 2'b00;
  logic [DW-1:0] wr_data = '0, rd_data;
  logic [OFW-1:0] ld_empty_ofs = '0, ld_full_ofs = '0;
  logic rd_flag, wr_flag, ae_flag, af_flag;

  fifo_dm #(.DW(DW), .DEPTH(D), .OFW(OFW)) dut_i (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .ofs_sel(ofs_sel),
    .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
    .rd_flag(rd_flag), .wr_flag(wr_flag), .ae_flag(ae_flag), .af_flag(af_flag),
    .ld_en(ld_en), .ld_empty_ofs(ld_empty_ofs), .ld_full_ofs(ld_full_ofs)
  );

  int checks = 0, fails = 0;
  string phase = "";
  logic [DW-1:0] sbq[$];
  int occ, occ1, occ2, n0, m0, n1, m1;
  bit ov0, ov1, ov2, fw;
  logic [15:0] lf = 16'hACE1;

  function automatic int sel_value(input logic [1:0] c);
    if (c == 2'b00) return 7;
    if (c == 2'b10) return 63;
    if (c == 2'b01) return 127;
    return 255;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL [%s] %s actual=%0h expected=%0h", phase, req, act, exp);
    end
  endtask

  task automatic do_reset(input bit fmode, input logic [1:0] sel);
    @(posedge clk); #2;
    rst_n = 1'b0; mode_sel = fmode; ofs_sel = sel;
    wr_en = 1'b0; rd_en = 1'b0; ld_en = 1'b0;
    repeat (3) @(posedge clk);
    #2;
    phase = "R2 reset";
    chk("R2 rd_flag", 32'(rd_flag), fmode ? 32'd1 : 32'd0);
    chk("R2 wr_flag", 32'(wr_flag), fmode ? 32'd0 : 32'd1);
    chk("R2 ae_flag", 32'(ae_flag), 32'd0);
    chk("R2 af_flag", 32'(af_flag), 32'd1);
    rst_n = 1'b1;
    fw = fmode; sbq.delete();
    occ = 0; occ1 = 0; occ2 = 0; ov0 = 0; ov1 = 0; ov2 = 0;
    n0 = sel_value(sel); m0 = n0; n1 = n0; m1 = m0;
  endtask

  // driver + monitor for one clock: predicts acceptance, scoreboards data, checks flags
  task automatic step(input bit w, input logic [DW-1:0] d, input bit r,
                      input bit ld = 1'b0, input int ln = 0, input int lm = 0);
    bit wacc, racc;
    logic [DW-1:0] exp_w;
    racc = r && (fw ? ov0 : (occ > 0));
    wacc = w && (occ < (fw ? D + 1 : D));
    wr_en = w; wr_data = d; rd_en = r; ld_en = ld;
    ld_empty_ofs = OFW'(ln); ld_full_ofs = OFW'(lm);
    @(posedge clk); #2;
    occ2 = occ1; occ1 = occ; ov2 = ov1; ov1 = ov0; n1 = n0; m1 = m0;
    if (ld) begin n0 = ln; m0 = lm; end
    occ = occ + int'(wacc) - int'(racc);
    if (wacc) sbq.push_back(d);
    if (racc) begin
      exp_w = sbq.pop_front();
      if (!fw) chk("R3 read word", 32'(rd_data), 32'(exp_w));
    end
    ov0 = fw && (occ > 0) && (occ1 > 0);
    if (ov0) chk("R5 head word", 32'(rd_data), 32'(sbq[0]));
    if (fw) begin
      chk("R5 rd_flag lag", 32'(rd_flag), 32'(!ov2));
      chk("R6 wr_flag", 32'(wr_flag), 32'(occ2 == D + 1));
    end else begin
      chk("R4 rd_flag", 32'(rd_flag), 32'(occ2 != 0));
      chk("R4 wr_flag", 32'(wr_flag), 32'(occ2 != D));
    end
    chk("R7 ae_flag (R11 R12 offsets)", 32'(ae_flag), 32'(occ1 > n1 + int'(fw)));
    chk("R8 af_flag (R11 R12 offsets)", 32'(af_flag), 32'(!(occ1 + m1 >= D + int'(fw))));
  endtask

  task automatic run(input bit fmode, input logic [1:0] sel);
    bit w, r;
    do_reset(fmode, sel);
    mode_sel = !fmode;
    phase = "R1 R9 empty reads";
    repeat (3) step(1'b0, '0, 1'b1);
    phase = "R4 R5 first word";
    step(1'b1, 8'hA5, 1'b0);
    repeat (5) step(1'b0, '0, 1'b0);
    step(1'b0, '0, 1'b1);
    repeat (3) step(1'b0, '0, 1'b0);
    phase = "R6 R10 overfill";
    for (int i = 0; i < D + 3; i++) step(1'b1, DW'(i), 1'b0);
    repeat (3) step(1'b0, '0, 1'b0);
    if (!fmode) begin
      phase = "R10 full read and write";
      step(1'b1, 8'hEE, 1'b1);
      repeat (3) step(1'b0, '0, 1'b0);
    end
    phase = "R3 R9 drain";
    for (int i = 0; i < D + 5; i++) step(1'b0, '0, 1'b1);
    repeat (3) step(1'b0, '0, 1'b0);
    phase = "R11 R12 mixed";
    for (int i = 0; i < 300; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      w = lf[0] | lf[3];
      r = lf[1] & lf[6];
      if (i > 150) r = lf[1] | lf[6];
      if (fw && occ == 1 && ov0 && r) w = 1'b0;
      if (i == 100) step(w, lf[15:8], r, 1'b1, 20, 30);
      else          step(w, lf[15:8], r);
    end
  endtask

  initial begin
    #(8 * 200000);
    checks++; fails++;
    $display("FAIL [watchdog] run did not end actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    run(1'b0, 2'b00);
    run(1'b1, 2'b00);
    run(1'b0, 2'b11);
    run(1'b1, 2'b01);
    run(1'b0, 2'b10);
    run(1'b1, 2'b10);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule